// File: doc/BRIEF.md
# External Memory Bus Interface Unit

This unit sits between a processor core and the chip's external pins. It carries one single-word transfer at a time over a 16-bit address bus and a 16-bit bidirectional data bus. The core presents a request with a direction, a target space (program, data or I/O), an address and, for writes, a data word. The unit latches the request. It then drives the address, the matching active-low space strobe, the direction line and the read strobe. The transfer is stretched one cycle at a time for as long as the external ready input is sampled low.

When ready is sampled high, the transfer ends. The unit gives the core a one-cycle done pulse, and on reads it also presents the word captured from the data bus. A mode input turns the read strobe pin into the inverse of the direction line. An active-low float input releases every pin group. Pin drive is modelled as one output-enable per group (address, write data, control), so the block stays synthesizable. Sequencing carries on unchanged while the pins are released.

Top module: `xbus_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `rsp_done` is 0, `rsp_rdata` is 0, all three space strobes are 1, `ext_rw` is 1, `ext_dout_oe` is 0, and `ext_rd_n` is 1 when `rd_mode` is 0.
- R2: During a transfer, space code 0 drives `ext_prog_n` low, code 1 drives `ext_data_n` low and code 2 drives `ext_io_n` low. The other strobes stay high. Code 3 drives no strobe low. Outside a transfer all strobes are high.
- R3: `ext_rw` is 0 only during a write transfer, and it is 1 otherwise. During a write transfer with `ext_off_n` high, `ext_dout_oe` is 1 and `ext_dout` carries the accepted write word. At all other times `ext_dout_oe` is 0.
- R4: With `rd_mode` at 0, `ext_rd_n` is 0 throughout a read transfer in any space and is 1 otherwise.
- R5: A transfer lasts one bus cycle plus one cycle for each clock edge at which `ext_ready` is sampled low. Address and strobes stay unchanged across those wait cycles.
- R6: In the cycle after the edge at which `ext_ready` is sampled high during a transfer, `rsp_done` is 1 for exactly one cycle and `req_ready` is 1 again.
- R7: On a read, `ext_din` is captured at the completing edge and shown on `rsp_rdata` together with the done pulse. `rsp_rdata` changes only when a read completes.
- R8: With `rd_mode` at 1, `ext_rd_n` equals the inverse of `ext_rw` in every cycle.
- R9: While `ext_off_n` is 0, `ext_addr_oe`, `ext_dout_oe` and `ext_ctl_oe` are all 0. Both enables `ext_addr_oe` and `ext_ctl_oe` are 1 while `ext_off_n` is 1. Transfer timing does not depend on `ext_off_n`.
- R10: `req_ready` is 0 for the whole of a transfer, wait cycles included. Request inputs that change during that time have no effect on the transfer being carried out.
- R11: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `ext_addr` shows the accepted address from the next cycle and holds it until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Target space: 0 program, 1 data, 2 I/O, 3 none |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| rd_mode | input | 1 | 1 = read strobe pin carries inverted direction |
| ext_off_n | input | 1 | Active-low float of all pin groups |
| ext_ready | input | 1 | External ready, sampled each bus cycle |
| ext_addr | output | 16 | Address bus value |
| ext_addr_oe | output | 1 | Address bus drive enable |
| ext_dout | output | 16 | Data bus value driven on writes |
| ext_dout_oe | output | 1 | Data bus drive enable |
| ext_din | input | 16 | Data bus value seen from the pins |
| ext_prog_n | output | 1 | Program space strobe, active low |
| ext_data_n | output | 1 | Data space strobe, active low |
| ext_io_n | output | 1 | I/O space strobe, active low |
| ext_rw | output | 1 | Direction, 1 read, 0 write |
| ext_rd_n | output | 1 | Read strobe, or inverted direction in mode 1 |
| ext_ctl_oe | output | 1 | Drive enable for strobes, direction and read strobe |

## Verification
Two things can fall in the same cycle: the end of a wait-stretched transfer and a release of the pins through the float input. The bench pulls `ext_off_n` low during a multi-wait read and raises it again partway through. It then checks that the done pulse, the captured word and the return of `req_ready` arrive in exactly the cycles the ready pattern dictates, while every enable reads 0 during the float. A second collision arises when the core holds `req_valid` with altered fields through a transfer: those changes must not touch the pins, and the transfer must complete as accepted.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int SPACE_W = 2;
    localparam int N_SPACE = 3;

    typedef enum logic [SPACE_W-1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic              wr;
        space_e            space;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic strobe_n(input logic active, input space_e sp, input int idx);
        return !(active && (int'(sp) == idx));
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_t             req_in,
    output logic              req_ready,
    input  logic              ext_ready,
    input  logic [DATA_W-1:0] ext_din,
    output logic              busy,
    output xfer_t             cur,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    bus_state_e state_q;
    xfer_t      cur_q;
    logic       done_q;
    logic [DATA_W-1:0] rdata_q;

    logic accept;
    logic finish;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign finish = (state_q == ST_XFER) && ext_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_q   <= req_in;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        if (!cur_q.wr) begin
                            rdata_q <= ext_din;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_XFER);
    assign cur       = cur_q;
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  logic               busy,
    input  xfer_t              cur,
    input  logic               rd_mode,
    input  logic               off_n,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ext_addr_oe,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_dout_oe,
    output logic [N_SPACE-1:0] sel_n,
    output logic               ext_rw,
    output logic               ext_rd_n,
    output logic               ext_ctl_oe
);

    logic rd_active;
    logic wr_active;

    assign wr_active = busy && cur.wr;
    assign rd_active = busy && !cur.wr;

    for (genvar g = 0; g < N_SPACE; g++) begin : g_sel
        assign sel_n[g] = strobe_n(busy, cur.space, g);
    end

    assign ext_rw   = !wr_active;
    assign ext_rd_n = rd_mode ? !ext_rw : !rd_active;

    assign ext_addr    = cur.addr;
    assign ext_dout    = cur.wdata;
    assign ext_addr_oe = off_n;
    assign ext_ctl_oe  = off_n;
    assign ext_dout_oe = off_n && wr_active;

endmodule

// File: rtl/xbus_unit.sv
module xbus_unit
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_space,
    input  logic [15:0]       req_addr,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    input  logic              rd_mode,
    input  logic              ext_off_n,
    input  logic              ext_ready,
    output logic [15:0]       ext_addr,
    output logic              ext_addr_oe,
    output logic [15:0]       ext_dout,
    output logic              ext_dout_oe,
    input  logic [15:0]       ext_din,
    output logic              ext_prog_n,
    output logic              ext_data_n,
    output logic              ext_io_n,
    output logic              ext_rw,
    output logic              ext_rd_n,
    output logic              ext_ctl_oe
);

    xfer_t              req_in;
    xfer_t              cur;
    logic               busy;
    logic [N_SPACE-1:0] sel_n;

    assign req_in.wr    = req_write;
    assign req_in.space = space_e'(req_space);
    assign req_in.addr  = req_addr;
    assign req_in.wdata = req_wdata;

    xbus_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .ext_ready (ext_ready),
        .ext_din   (ext_din),
        .busy      (busy),
        .cur       (cur),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    xbus_pins i_pins (
        .busy        (busy),
        .cur         (cur),
        .rd_mode     (rd_mode),
        .off_n       (ext_off_n),
        .ext_addr    (ext_addr),
        .ext_addr_oe (ext_addr_oe),
        .ext_dout    (ext_dout),
        .ext_dout_oe (ext_dout_oe),
        .sel_n       (sel_n),
        .ext_rw      (ext_rw),
        .ext_rd_n    (ext_rd_n),
        .ext_ctl_oe  (ext_ctl_oe)
    );

    assign ext_prog_n = sel_n[int'(SP_PROG)];
    assign ext_data_n = sel_n[int'(SP_DATA)];
    assign ext_io_n   = sel_n[int'(SP_IO)];

endmodule

// File: rtl/xbus_unit_chk.sv
module xbus_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_done,
    input logic        rd_mode,
    input logic        ext_off_n,
    input logic        ext_ready,
    input logic [15:0] ext_addr,
    input logic        ext_addr_oe,
    input logic        ext_dout_oe,
    input logic        ext_ctl_oe,
    input logic        ext_prog_n,
    input logic        ext_data_n,
    input logic        ext_io_n,
    input logic        ext_rw,
    input logic        ext_rd_n
);

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!ext_prog_n, !ext_data_n, !ext_io_n}) <= 1);

    a_r2_idle_strobes: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ext_prog_n && ext_data_n && ext_io_n));

    a_r3_write_drives_data: assert property (@(posedge clk) disable iff (rst)
        (ext_ctl_oe && !ext_rw) |-> ext_dout_oe);

    a_r4_read_strobe_only_reads: assert property (@(posedge clk) disable iff (rst)
        (!rd_mode && !ext_rd_n) |-> (ext_rw && !req_ready));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !ext_ready) |=> (!req_ready && $stable(ext_addr)));

    a_r6_done_follows_ready: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && ext_ready) |=> (rsp_done && req_ready));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r9_float_all: assert property (@(posedge clk) disable iff (rst)
        !ext_off_n |-> !(ext_addr_oe || ext_dout_oe || ext_ctl_oe));

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(!req_ready));

endmodule

bind xbus_unit xbus_unit_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rd_mode     (rd_mode),
    .ext_off_n   (ext_off_n),
    .ext_ready   (ext_ready),
    .ext_addr    (ext_addr),
    .ext_addr_oe (ext_addr_oe),
    .ext_dout_oe (ext_dout_oe),
    .ext_ctl_oe  (ext_ctl_oe),
    .ext_prog_n  (ext_prog_n),
    .ext_data_n  (ext_data_n),
    .ext_io_n    (ext_io_n),
    .ext_rw      (ext_rw),
    .ext_rd_n    (ext_rd_n)
);

// File: tb/test_xbus_unit.sv
`timescale 1ns/1ps
module test_xbus_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [15:0] req_wdata = 16'h0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rd_mode = 1'b0;
    logic        ext_off_n = 1'b1;
    logic        ext_ready = 1'b1;
    logic [15:0] ext_addr;
    logic        ext_addr_oe;
    logic [15:0] ext_dout;
    logic        ext_dout_oe;
    logic [15:0] ext_din = 16'h0;
    logic        ext_prog_n, ext_data_n, ext_io_n;
    logic        ext_rw, ext_rd_n, ext_ctl_oe;

    always #4 clk = ~clk;

    xbus_unit i_xbus_unit (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // reference model state
    bit          m_busy = 0, m_done = 0, m_wr = 0;
    int          m_space = 0;
    logic [15:0] m_addr = 0, m_wdata = 0, m_rdata = 0;
    int          m_len = 0;
    int          wait_left = 0;
    logic [15:0] din_val = 16'h0;
    bit          run_cmp = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_wr = 0; m_space = 0;
            m_addr = 0; m_wdata = 0; m_rdata = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_len++;
                if (ext_ready) begin
                    m_busy = 0;
                    m_done = 1;
                    if (!m_wr) m_rdata = ext_din;
                end
            end else if (req_valid) begin
                m_busy = 1; m_len = 0;
                m_wr = req_write; m_space = int'(req_space);
                m_addr = req_addr; m_wdata = req_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (m_busy && wait_left > 0) begin
            ext_ready = 1'b0;
            wait_left--;
        end else begin
            ext_ready = 1'b1;
        end
        ext_din = ext_ready ? din_val : ~din_val;
        #2;
        if (run_cmp) begin
            bit e_rw, e_rd, e_doe;
            e_rw  = !(m_busy && m_wr);
            e_rd  = rd_mode ? !e_rw : !(m_busy && !m_wr);
            e_doe = ext_off_n && m_busy && m_wr;
            chk(ext_prog_n == !(m_busy && m_space == 0), "R2", "prog_n", ext_prog_n, !(m_busy && m_space == 0));
            chk(ext_data_n == !(m_busy && m_space == 1), "R2", "data_n", ext_data_n, !(m_busy && m_space == 1));
            chk(ext_io_n == !(m_busy && m_space == 2), "R2", "io_n", ext_io_n, !(m_busy && m_space == 2));
            chk(ext_rw == e_rw, "R3", "rw", ext_rw, e_rw);
            chk(ext_dout_oe == e_doe, "R3", "dout_oe", ext_dout_oe, e_doe);
            if (e_doe) chk(ext_dout == m_wdata, "R3", "dout", ext_dout, m_wdata);
            chk(ext_rd_n == e_rd, rd_mode ? "R8" : "R4", "rd_n", ext_rd_n, e_rd);
            chk(req_ready == !m_busy, "R10", "req_ready", req_ready, !m_busy);
            chk(ext_addr == m_addr, "R11", "addr", ext_addr, m_addr);
            chk(rsp_done == m_done, "R6", "done", rsp_done, m_done);
            chk(rsp_rdata == m_rdata, "R7", "rdata", rsp_rdata, m_rdata);
            chk(ext_addr_oe == ext_off_n && ext_ctl_oe == ext_off_n, "R9", "addr/ctl oe",
                {ext_addr_oe, ext_ctl_oe}, {ext_off_n, ext_off_n});
        end
    end

    task automatic xfer(input bit wr, input logic [1:0] sp, input logic [15:0] a,
                        input logic [15:0] d, input int waits, input bit junk);
        int len_seen;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_space = sp; req_addr = a; req_wdata = d;
        din_val = d; wait_left = waits;
        @(negedge clk);
        while (!m_busy) @(negedge clk);
        if (junk) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~wr; req_space = sp + 2'd1;
        end else begin
            req_valid = 0;
        end
        while (m_busy) @(negedge clk);
        req_valid = 0;
        len_seen = m_len;
        // R5: bus cycles equal one plus the number of low-ready samples
        chk(len_seen == waits + 1, "R5", "transfer length", len_seen, waits + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: values during reset
        chk(req_ready == 1 && rsp_done == 0, "R1", "ready/done in reset", {req_ready, rsp_done}, 2'b10);
        chk({ext_prog_n, ext_data_n, ext_io_n, ext_rw, ext_rd_n} == 5'b11111, "R1", "strobes in reset",
            {ext_prog_n, ext_data_n, ext_io_n, ext_rw, ext_rd_n}, 5'b11111);
        chk(ext_dout_oe == 0 && rsp_rdata == 0, "R1", "data oe/rdata in reset", {ext_dout_oe, rsp_rdata}, 0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        #2;
        chk(req_ready == 1 && ext_dout_oe == 0 && ext_rw == 1, "R1", "after reset",
            {req_ready, ext_dout_oe, ext_rw}, 3'b101);
        run_cmp = 1;

        xfer(0, 2'd0, 16'h1234, 16'hA5A5, 0, 0);
        xfer(0, 2'd1, 16'h8001, 16'h5A5A, 2, 0);
        xfer(0, 2'd2, 16'hFFFF, 16'hC3C3, 3, 0);
        xfer(1, 2'd1, 16'h0F0F, 16'hBEEF, 1, 0);
        xfer(1, 2'd0, 16'h0000, 16'h0001, 0, 0);
        xfer(1, 2'd2, 16'h7FFE, 16'h8000, 2, 0);
        xfer(0, 2'd3, 16'h4444, 16'h1111, 1, 0);
        // R10: request fields change while the transfer runs
        xfer(1, 2'd0, 16'h2222, 16'h3333, 3, 1);
        xfer(0, 2'd1, 16'h5555, 16'h6666, 2, 1);
        // R8: read strobe pin as inverted direction
        rd_mode = 1;
        xfer(0, 2'd2, 16'h1357, 16'h2468, 1, 0);
        xfer(1, 2'd1, 16'h9ABC, 16'hDEF0, 2, 0);
        rd_mode = 0;
        // R9: float during a stretched read, released mid-transfer
        fork
            xfer(0, 2'd1, 16'hCAFE, 16'hF00D, 5, 0);
            begin
                @(negedge clk); ext_off_n = 0;
                repeat (3) @(negedge clk);
                ext_off_n = 1;
            end
        join
        ext_off_n = 0;
        xfer(1, 2'd0, 16'h0101, 16'h0202, 1, 0);
        ext_off_n = 1;
        repeat (4) @(negedge clk);
        finish_run();
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

endmodule